// File: doc/BRIEF.md
# SEC-DED Merge Codec

This block protects a 64-bit memory word with 8 check bits. It corrects any single flipped bit and reports any two flipped bits. The read side takes a word and its stored check bits from memory. It forms a syndrome, repairs the word where it can, and raises active-low error and uncorrectable-error flags. Neither flag is held in a register.

The write side merges bytes for partial-word writes. Under a per-byte keep mask, each byte comes either from the repaired memory word or from the incoming system word. Check bits are then generated over the merged result. The same pass produces even parity per byte over the repaired word. It also checks the parity of the system bytes being written.

The codec is purely combinational. Every result settles within the cycle its inputs arrive in. A stream handshake would add nothing here, so there is none; the enclosing pipeline supplies the registers, latches, FIFOs and pad drivers.

Top module: `secded_merge_codec`

## Requirements
- R1: `wr_chk[r]` is the XOR of every `wr_data[i]` whose column has bit r set. The column of data bit i is the i-th odd-weight 8-bit value in a fixed order: all weight-3 values in ascending numeric order, then weight-5 values in ascending order.
- R2: `syndrome` equals the check bits regenerated from `rd_data` XOR `rd_chk`.
- R3: When exactly one data bit of `rd_data` is flipped, `fix_data` holds the original word, `err_n` is 0 and `merr_n` is 1.
- R4: When exactly one bit of `rd_chk` is flipped, `fix_data` equals `rd_data`, `err_n` is 0 and `merr_n` is 1.
- R5: When any two bits across `rd_data` and `rd_chk` are flipped, `err_n` and `merr_n` are both 0 and `fix_data` equals `rd_data` unchanged.
- R6: With consistent check bits, `syndrome` is 0, both flags are 1 and `fix_data` equals `rd_data`.
- R7: Byte b of `wr_data` is byte b of `fix_data` when `keep_mem[b]` is 1, else byte b of `sys_data`. Byte b is bits 8b+7 down to 8b.
- R8: `fix_par[b]` is the XOR of the 8 bits of byte b of `fix_data` (even parity).
- R9: `par_err_n` is 0 exactly when some byte b with `keep_mem[b]` = 0 has `sys_par[b]` unequal to the XOR of byte b of `sys_data`. Bytes with `keep_mem[b]` = 1 have no effect on it.
- R10: `cb_syn_out` is `wr_chk` when `mem_oe_n` is 0. It is `syndrome` when `mem_oe_n` is 1 and `syn_sel` is 1. It is all zeros when both are 1 and 0 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rd_data | input | 64 | Word read from memory |
| rd_chk | input | 8 | Stored check bits for rd_data |
| sys_data | input | 64 | New data from the system side |
| sys_par | input | 8 | Even parity per byte of sys_data |
| keep_mem | input | 8 | Per byte: 1 keeps the repaired memory byte, 0 takes the system byte |
| mem_oe_n | input | 1 | Low selects generated check bits on cb_syn_out |
| syn_sel | input | 1 | With mem_oe_n high, selects the syndrome on cb_syn_out |
| fix_data | output | 64 | Repaired read word |
| fix_par | output | 8 | Even parity per byte of fix_data |
| syndrome | output | 8 | Read syndrome |
| err_n | output | 1 | Low on any detected error |
| merr_n | output | 1 | Low on an uncorrectable error |
| par_err_n | output | 1 | Low on a parity mismatch in a written system byte |
| wr_data | output | 64 | Merged word for write-back |
| wr_chk | output | 8 | Check bits generated over wr_data |
| cb_syn_out | output | 8 | Check bits or syndrome, per the output select |

## Verification
There are no registers between inputs and outputs. Every result is due in the same cycle its stimulus is applied. The bench changes inputs on a rising clock edge and reads all outputs at the following falling edge, once the combinational paths have settled and before the next change. Each scenario applies one stimulus per cycle, so no result is ever compared against an earlier or later input set.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int BYTE_W = 8;

  // Column of data bit idx: odd-weight values of weight 3 and up,
  // lowest weight first, ascending numeric value within a weight.
  function automatic int hcol(input int idx, input int cw);
    int n;
    int res;
    n = 0;
    res = 0;
    for (int w = 3; w <= cw; w += 2) begin
      for (int v = 0; v < (1 << cw); v++) begin
        if ($countones(v) == w) begin
          if (n == idx) res = v;
          n++;
        end
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import secded_pkg::*;
#(
  parameter int DW = 64,
  parameter int CW = 8
) (
  input  logic [DW-1:0] data,
  output logic [CW-1:0] chk
);
  for (genvar r = 0; r < CW; r++) begin : g_row
    logic [DW-1:0] mask;
    for (genvar i = 0; i < DW; i++) begin : g_col
      localparam int COL = hcol(i, CW);
      assign mask[i] = COL[r];
    end
    assign chk[r] = ^(data & mask);
  end
endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import secded_pkg::*;
#(
  parameter int DW = 64,
  parameter int CW = 8
) (
  input  logic [DW-1:0] data,
  input  logic [CW-1:0] chk_in,
  output logic [CW-1:0] syn,
  output logic [DW-1:0] fixed,
  output logic          err_n,
  output logic          merr_n
);
  logic [CW-1:0] regen;
  logic [DW-1:0] hit;
  logic          chk_hit;
  logic          nonzero;

  secded_enc #(.DW(DW), .CW(CW)) u_regen (
    .data (data),
    .chk  (regen)
  );

  assign syn = regen ^ chk_in;

  for (genvar i = 0; i < DW; i++) begin : g_match
    localparam logic [CW-1:0] COLV = CW'(hcol(i, CW));
    assign hit[i] = (syn == COLV);
  end

  assign fixed   = data ^ hit;
  assign chk_hit = $onehot(syn);
  assign nonzero = |syn;
  assign err_n   = ~nonzero;
  assign merr_n  = ~(nonzero & ~(|hit) & ~chk_hit);
endmodule

// File: rtl/secded_bytepar.sv
module secded_bytepar
  import secded_pkg::*;
#(
  parameter int NB = 8
) (
  input  logic [NB*BYTE_W-1:0] word,
  output logic [NB-1:0]        par
);
  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign par[b] = ^word[b*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/secded_merge_codec.sv
module secded_merge_codec
  import secded_pkg::*;
#(
  parameter int DW = 64,
  parameter int CW = 8
) (
  input  logic [DW-1:0]        rd_data,
  input  logic [CW-1:0]        rd_chk,
  input  logic [DW-1:0]        sys_data,
  input  logic [DW/BYTE_W-1:0] sys_par,
  input  logic [DW/BYTE_W-1:0] keep_mem,
  input  logic                 mem_oe_n,
  input  logic                 syn_sel,
  output logic [DW-1:0]        fix_data,
  output logic [DW/BYTE_W-1:0] fix_par,
  output logic [CW-1:0]        syndrome,
  output logic                 err_n,
  output logic                 merr_n,
  output logic                 par_err_n,
  output logic [DW-1:0]        wr_data,
  output logic [CW-1:0]        wr_chk,
  output logic [CW-1:0]        cb_syn_out
);
  localparam int NB = DW / BYTE_W;

  logic [NB-1:0] sys_gen;

  secded_dec #(.DW(DW), .CW(CW)) u_dec (
    .data   (rd_data),
    .chk_in (rd_chk),
    .syn    (syndrome),
    .fixed  (fix_data),
    .err_n  (err_n),
    .merr_n (merr_n)
  );

  secded_bytepar #(.NB(NB)) u_fix_par (
    .word (fix_data),
    .par  (fix_par)
  );

  secded_bytepar #(.NB(NB)) u_sys_par (
    .word (sys_data),
    .par  (sys_gen)
  );

  assign par_err_n = ~|((sys_gen ^ sys_par) & ~keep_mem);

  for (genvar b = 0; b < NB; b++) begin : g_merge
    assign wr_data[b*BYTE_W +: BYTE_W] = keep_mem[b] ? fix_data[b*BYTE_W +: BYTE_W]
                                                     : sys_data[b*BYTE_W +: BYTE_W];
  end

  secded_enc #(.DW(DW), .CW(CW)) u_wr_enc (
    .data (wr_data),
    .chk  (wr_chk)
  );

  always_comb begin
    if (!mem_oe_n)    cb_syn_out = wr_chk;
    else if (syn_sel) cb_syn_out = syndrome;
    else              cb_syn_out = '0;
  end
endmodule

// File: rtl/secded_codec_chk.sv
module secded_codec_chk
  import secded_pkg::*;
#(
  parameter int DW = 64,
  parameter int CW = 8
) (
  input logic [DW-1:0]        rd_data,
  input logic [DW-1:0]        sys_data,
  input logic [DW/BYTE_W-1:0] keep_mem,
  input logic                 mem_oe_n,
  input logic                 syn_sel,
  input logic [DW-1:0]        fix_data,
  input logic                 err_n,
  input logic                 merr_n,
  input logic                 par_err_n,
  input logic [DW-1:0]        wr_data,
  input logic [CW-1:0]        cb_syn_out
);
  localparam int NB = DW / BYTE_W;

  always_comb begin
    // R3: a correctable error changes at most one data bit
    p_one_fix_r3: assert (err_n || !merr_n || $countones(fix_data ^ rd_data) <= 1);
    // R5: uncorrectable implies error, and data passes untouched
    p_merr_err_r5: assert (merr_n || !err_n);
    p_merr_keep_r5: assert (merr_n || fix_data == rd_data);
    // R6: no error, no change
    p_clean_keep_r6: assert (!err_n || fix_data == rd_data);
    // R9: with every byte kept, parity never flags
    p_par_kept_r9: assert (!(&keep_mem) || par_err_n);
    // R10: idle select drives zeros
    p_idle_out_r10: assert (!(mem_oe_n && !syn_sel) || cb_syn_out == '0);
  end

  for (genvar b = 0; b < NB; b++) begin : g_mchk
    always_comb begin
      // R7: each merged byte comes from its selected source
      p_merge_src_r7: assert (wr_data[b*BYTE_W +: BYTE_W] ==
        (keep_mem[b] ? fix_data[b*BYTE_W +: BYTE_W] : sys_data[b*BYTE_W +: BYTE_W]));
    end
  end
endmodule

bind secded_merge_codec secded_codec_chk #(.DW(DW), .CW(CW)) u_chk (
  .rd_data    (rd_data),
  .sys_data   (sys_data),
  .keep_mem   (keep_mem),
  .mem_oe_n   (mem_oe_n),
  .syn_sel    (syn_sel),
  .fix_data   (fix_data),
  .err_n      (err_n),
  .merr_n     (merr_n),
  .par_err_n  (par_err_n),
  .wr_data    (wr_data),
  .cb_syn_out (cb_syn_out)
);

// File: tb/tb_secded_merge_codec.sv
module tb_secded_merge_codec;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 64;
  localparam int CW = 8;
  localparam int NB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [DW-1:0] rd_data, sys_data, fix_data, wr_data;
  logic [CW-1:0] rd_chk, syndrome, wr_chk, cb_syn_out;
  logic [NB-1:0] sys_par, keep_mem, fix_par;
  logic mem_oe_n, syn_sel, err_n, merr_n, par_err_n;

  secded_merge_codec dut (
    .rd_data(rd_data), .rd_chk(rd_chk), .sys_data(sys_data), .sys_par(sys_par),
    .keep_mem(keep_mem), .mem_oe_n(mem_oe_n), .syn_sel(syn_sel),
    .fix_data(fix_data), .fix_par(fix_par), .syndrome(syndrome),
    .err_n(err_n), .merr_n(merr_n), .par_err_n(par_err_n),
    .wr_data(wr_data), .wr_chk(wr_chk), .cb_syn_out(cb_syn_out)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [CW-1:0] hm [DW];

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all reqs): actual timeout expected completion");
      summary();
      $finish;
    end
  end

  task automatic build_table();
    int n = 0;
    for (int w = 3; w <= CW; w += 2)
      for (int v = 0; v < 256; v++)
        if ($countones(v) == w && n < DW) begin
          hm[n] = v[CW-1:0];
          n++;
        end
  endtask

  function automatic logic [CW-1:0] ref_enc(input logic [DW-1:0] d);
    logic [CW-1:0] c = '0;
    for (int i = 0; i < DW; i++) if (d[i]) c ^= hm[i];
    return c;
  endfunction

  function automatic logic [NB-1:0] ref_par(input logic [DW-1:0] d);
    logic [NB-1:0] p;
    for (int b = 0; b < NB; b++) p[b] = ^d[b*8 +: 8];
    return p;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [DW-1:0] rd, input logic [CW-1:0] rc,
                       input logic [DW-1:0] sd, input logic [NB-1:0] sp,
                       input logic [NB-1:0] km, input logic oe_n, input logic ss);
    @(posedge clk);
    rd_data = rd; rd_chk = rc; sys_data = sd; sys_par = sp;
    keep_mem = km; mem_oe_n = oe_n; syn_sel = ss;
    @(negedge clk);
  endtask

  function automatic logic [DW-1:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  task automatic t_reset();
    drive('0, '0, '0, '0, '0, 1'b1, 1'b0);
    chk("R6", "reset fix_data", fix_data, '0);
    chk("R6", "reset flags", {err_n, merr_n}, 2'b11);
    chk("R9", "reset par_err_n", par_err_n, 1'b1);
    chk("R10", "reset cb_syn_out", cb_syn_out, '0);
    rst_n = 1'b1;
  endtask

  task automatic t_clean();
    logic [DW-1:0] pats [6];
    pats[0] = '0; pats[1] = '1; pats[2] = 64'hA5A5_5A5A_0F0F_F0F0;
    pats[3] = 64'h1; pats[4] = 64'h8000_0000_0000_0000; pats[5] = rnd64();
    for (int k = 0; k < 26; k++) begin
      logic [DW-1:0] d = (k < 6) ? pats[k] : rnd64();
      drive(d, ref_enc(d), d, ref_par(d), '0, 1'b0, 1'b0);
      chk("R1", "wr_chk", wr_chk, ref_enc(d));
      chk("R2", "clean syndrome", syndrome, '0);
      chk("R6", "clean data", fix_data, d);
      chk("R6", "clean flags", {err_n, merr_n}, 2'b11);
      chk("R8", "fix_par", fix_par, ref_par(d));
    end
  endtask

  task automatic t_single_data();
    logic [DW-1:0] d = rnd64();
    logic [CW-1:0] c = ref_enc(d);
    for (int i = 0; i < DW; i++) begin
      logic [DW-1:0] bad = d ^ (64'h1 << i);
      drive(bad, c, '0, '0, '0, 1'b1, 1'b1);
      chk("R3", "corrected data", fix_data, d);
      chk("R3", "flags", {err_n, merr_n}, 2'b01);
      chk("R2", "syndrome", syndrome, hm[i]);
    end
  endtask

  task automatic t_single_chk();
    logic [DW-1:0] d = rnd64();
    logic [CW-1:0] c = ref_enc(d);
    for (int j = 0; j < CW; j++) begin
      drive(d, c ^ (8'h1 << j), '0, '0, '0, 1'b1, 1'b1);
      chk("R4", "data untouched", fix_data, d);
      chk("R4", "flags", {err_n, merr_n}, 2'b01);
    end
  endtask

  task automatic t_double();
    for (int k = 0; k < 300; k++) begin
      logic [DW-1:0] d = rnd64();
      logic [DW+CW-1:0] cw = {ref_enc(d), d};
      int p = $urandom_range(DW+CW-1, 0);
      int q = $urandom_range(DW+CW-1, 0);
      if (q == p) q = (p + 1) % (DW+CW);
      if (k == 0) begin p = DW; q = DW+CW-1; end
      cw[p] = ~cw[p];
      cw[q] = ~cw[q];
      drive(cw[DW-1:0], cw[DW+CW-1:DW], '0, '0, '0, 1'b1, 1'b0);
      chk("R5", "flags", {err_n, merr_n}, 2'b00);
      chk("R5", "data passed", fix_data, cw[DW-1:0]);
    end
  endtask

  task automatic t_merge();
    logic [NB-1:0] masks [5];
    masks[0] = 8'h00; masks[1] = 8'hFF; masks[2] = 8'h0F; masks[3] = 8'hA5; masks[4] = 8'h80;
    for (int k = 0; k < 5; k++) begin
      logic [DW-1:0] d = rnd64();
      logic [DW-1:0] s = rnd64();
      logic [DW-1:0] exp;
      int i = $urandom_range(DW-1, 0);
      for (int b = 0; b < NB; b++)
        exp[b*8 +: 8] = masks[k][b] ? d[b*8 +: 8] : s[b*8 +: 8];
      drive(d ^ (64'h1 << i), ref_enc(d), s, ref_par(s), masks[k], 1'b0, 1'b0);
      chk("R7", "merged word", wr_data, exp);
      chk("R1", "merged check bits", wr_chk, ref_enc(exp));
      chk("R10", "cb_syn_out chk", cb_syn_out, ref_enc(exp));
    end
  endtask

  task automatic t_parity();
    logic [DW-1:0] s = rnd64();
    logic [NB-1:0] gp = ref_par(s);
    drive('0, '0, s, gp, 8'h00, 1'b1, 1'b0);
    chk("R9", "good parity", par_err_n, 1'b1);
    for (int b = 0; b < NB; b++) begin
      drive('0, '0, s, gp ^ (8'h1 << b), 8'h00, 1'b1, 1'b0);
      chk("R9", "bad written byte", par_err_n, 1'b0);
      drive('0, '0, s, gp ^ (8'h1 << b), 8'h1 << b, 1'b1, 1'b0);
      chk("R9", "bad kept byte ignored", par_err_n, 1'b1);
    end
  endtask

  task automatic t_cbsyn();
    logic [DW-1:0] d = rnd64();
    logic [CW-1:0] c = ref_enc(d) ^ 8'h3C;
    drive(d, c, d, ref_par(d), '0, 1'b1, 1'b1);
    chk("R10", "syndrome out", cb_syn_out, 8'h3C);
    drive(d, c, d, ref_par(d), '0, 1'b1, 1'b0);
    chk("R10", "idle out", cb_syn_out, '0);
    drive(d, c, d, ref_par(d), '0, 1'b0, 1'b1);
    chk("R10", "check bits out", cb_syn_out, ref_enc(d));
  endtask

  initial begin
    build_table();
    rd_data = '0; rd_chk = '0; sys_data = '0; sys_par = '0;
    keep_mem = '0; mem_oe_n = 1'b1; syn_sel = 1'b0;
    t_reset();
    t_clean();
    t_single_data();
    t_single_chk();
    t_double();
    t_merge();
    t_parity();
    t_cbsyn();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule